// File: doc/BRIEF.md
# Silent-Stream Zero Flag Detector

This block watches a stream of stereo sample pairs and raises a flag once the input has stayed exactly silent for a long, unbroken run of sample periods. Downstream logic uses the flag to decide when to quiet its outputs. A sample period is counted only when a valid strobe arrives. The run is broken the moment either channel carries a non-zero value.

The flag also covers start-up. From the moment reset is applied, the flag is high, and it stays high while the block lines itself up with the word clock. Once the word clock has risen after reset, the next sample strobe is the first real data period. From then on the flag follows the zero-run rule alone. The run length is a power of two set by a parameter. Its default of 2^14 periods comes to roughly 0.37 s at a 44.1 kHz sample rate.

Top module: `zero_run_detector`

## Requirements
- R1: While `rst_n` is low, and after its release until start-up ends, `zero_flag_o` is 1 (active high).
- R2: Start-up ends only at the first `sample_valid_i` pulse that is sampled in a clock cycle after the one in which a word-clock rising edge was seen. A strobe before that edge, or in the same cycle as the edge, leaves the flag at 1. The strobe that ends start-up is itself counted as the first data period.
- R3: A word-clock rising edge is a low-to-high change between two consecutive clock samples of `word_clk_i`. A word clock that is already high when reset is released does not count as an edge.
- R4: A data period counts as silent only when `left_i` and `right_i` are both exactly zero. A non-zero value on either channel alone, including the most negative code 16'h8000, breaks the run.
- R5: The flag rises at the clock edge that samples the 2^RUN_LOG2-th consecutive silent strobe, and not one strobe earlier.
- R6: A strobe that carries a non-silent pair clears the run, and the flag reads 0 after that same clock edge.
- R7: The run count saturates at 2^RUN_LOG2, so the flag stays 1 through any number of further silent strobes.
- R8: Clock cycles without `sample_valid_i` neither advance nor break the run, and they do not change the flag.
- R9: Once start-up has ended, activity on `word_clk_i` has no effect on the run or on the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_clk_i | input | 1 | Word clock, sampled on `clk` |
| sample_valid_i | input | 1 | One-cycle strobe marking a new sample pair |
| left_i | input | SAMPLE_W | Left sample, two's complement |
| right_i | input | SAMPLE_W | Right sample, two's complement |
| zero_flag_o | output | 1 | High during start-up or after a long silent run |

## Verification
The silent-run rule is driven with several kinds of non-silent pair. The bench uses a pair with only the left channel set, including the most negative code, and a pair with only the right channel set, which separates a test of the whole pair from a test of one channel. It also sends runs that stop one strobe short of the threshold and then break, and runs that reach the threshold exactly, so that a counter off by one at either end is caught. Runs are sent with uneven idle gaps and with the word clock toggling, which shows that only strobes advance the count and that the word clock matters only during start-up. Start-up is checked with a word clock held high across reset release, with a strobe that lands in the same cycle as the edge, and with a reset applied in the middle of a run.

// File: rtl/zdet_pkg.sv
package zdet_pkg;

  typedef enum logic [1:0] {
    PH_AWAIT_EDGE = 2'd0,
    PH_AWAIT_DATA = 2'd1,
    PH_RUN        = 2'd2
  } phase_e;

  // Next value of a saturating run counter.
  function automatic int unsigned run_step(input int unsigned cur,
                                           input int unsigned limit,
                                           input logic        silent);
    if (!silent)
      return 0;
    else if (cur >= limit)
      return limit;
    else
      return cur + 1;
  endfunction

endpackage

// File: rtl/zdet_edge.sv
module zdet_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  // Reset to 1 so that a level already high at release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/zdet_phase.sv
module zdet_phase
  import zdet_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rise_i,
  input  logic   strobe_i,
  output phase_e phase_o,
  output logic   count_en_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_AWAIT_EDGE: if (rise_i)   phase_d = PH_AWAIT_DATA;
      PH_AWAIT_DATA: if (strobe_i) phase_d = PH_RUN;
      PH_RUN:        phase_d = PH_RUN;
      default:       phase_d = PH_AWAIT_EDGE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_AWAIT_EDGE;
    else        phase_q <= phase_d;
  end

  assign phase_o    = phase_q;
  // The strobe that ends start-up is counted as the first data period.
  assign count_en_o = strobe_i & (phase_q != PH_AWAIT_EDGE);
endmodule

// File: rtl/zdet_run_ctr.sv
module zdet_run_ctr
  import zdet_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RUN_LOG2 = 14,
  localparam int CNT_W   = RUN_LOG2 + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                silent_o,
  output logic                full_o,
  output logic [CNT_W-1:0]    cnt_o
);
  localparam int unsigned LIMIT = 1 << RUN_LOG2;

  logic [CNT_W-1:0] cnt_q;

  assign silent_o = (left_i == '0) && (right_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= CNT_W'(run_step(32'(cnt_q), LIMIT, silent_o));
  end

  assign full_o = (cnt_q == CNT_W'(LIMIT));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/zero_run_detector.sv
module zero_run_detector
  import zdet_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RUN_LOG2 = 14,
  localparam int CNT_W   = RUN_LOG2 + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_clk_i,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                zero_flag_o
);
  logic             word_rise;
  phase_e           phase;
  logic             count_en;
  logic             pair_silent;
  logic             run_full;
  logic [CNT_W-1:0] run_cnt;

  zdet_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (word_clk_i),
    .rise_o  (word_rise)
  );

  zdet_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (word_rise),
    .strobe_i   (sample_valid_i),
    .phase_o    (phase),
    .count_en_o (count_en)
  );

  zdet_run_ctr #(
    .SAMPLE_W (SAMPLE_W),
    .RUN_LOG2 (RUN_LOG2)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (count_en),
    .left_i   (left_i),
    .right_i  (right_i),
    .silent_o (pair_silent),
    .full_o   (run_full),
    .cnt_o    (run_cnt)
  );

  assign zero_flag_o = (phase != PH_RUN) | run_full;
endmodule

// File: rtl/zdet_checker.sv
module zdet_checker
  import zdet_pkg::*;
#(
  parameter int RUN_LOG2 = 14,
  localparam int CNT_W   = RUN_LOG2 + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_valid_i,
  input logic             word_rise,
  input phase_e           phase,
  input logic             count_en,
  input logic             pair_silent,
  input logic             run_full,
  input logic [CNT_W-1:0] run_cnt,
  input logic             zero_flag_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << RUN_LOG2;

  assert_wait_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_AWAIT_EDGE && !word_rise) |=> (phase == PH_AWAIT_EDGE));

  assert_no_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_AWAIT_EDGE) |=> (phase != PH_RUN));

  assert_init_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_AWAIT_DATA) |-> zero_flag_o);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && pair_silent && !run_full) |=> (run_cnt == CNT_W'($past(run_cnt) + 1'b1)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LIMIT);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !pair_silent) |=> !zero_flag_o);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_flag_o && phase == PH_RUN && !(sample_valid_i && !pair_silent)) |=> zero_flag_o);

  assert_rise_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_flag_o) |-> $past(count_en));
endmodule

bind zero_run_detector zdet_checker #(.RUN_LOG2(RUN_LOG2)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sample_valid_i (sample_valid_i),
  .word_rise      (word_rise),
  .phase          (phase),
  .count_en       (count_en),
  .pair_silent    (pair_silent),
  .run_full       (run_full),
  .run_cnt        (run_cnt),
  .zero_flag_o    (zero_flag_o)
);

// File: tb/zero_run_detector_tb.sv
`timescale 1ns/1ps
module zero_run_detector_tb;
  localparam int W     = 16;
  localparam int LOG2  = 4;
  localparam int LIMIT = 1 << LOG2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wclk = 1'b1;
  logic         valid = 1'b0;
  logic [W-1:0] left = '0;
  logic [W-1:0] right = '0;
  logic         flag;

  always #2.5 clk = ~clk;

  zero_run_detector #(.SAMPLE_W(W), .RUN_LOG2(LOG2)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .word_clk_i     (wclk),
    .sample_valid_i (valid),
    .left_i         (left),
    .right_i        (right),
    .zero_flag_o    (flag)
  );

  typedef struct {logic exp; string tag;} item_t;
  item_t sbq[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Independent model of start-up and the silent run.
  bit m_edge = 0;
  bit m_run  = 0;
  int m_cnt  = 0;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: zero_flag actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per strobe, one half-cycle after the edge.
  logic v_d = 1'b0;
  always @(posedge clk) v_d <= valid;
  always @(negedge clk) begin
    if (v_d) begin
      if (sbq.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: flag actual %0b expected none queued", flag);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(flag, it.exp, it.tag);
      end
    end
  end

  task automatic send(input logic [W-1:0] l, input logic [W-1:0] r,
                      input int gap, input string tag);
    @(negedge clk);
    left = l; right = r; valid = 1'b1;
    if (!m_run && m_edge) m_run = 1;
    if (m_run) begin
      if (l == 0 && r == 0) begin
        if (m_cnt < LIMIT) m_cnt++;
      end else m_cnt = 0;
    end
    sbq.push_back('{exp: (!m_run) || (m_cnt >= LIMIT), tag: tag});
    @(negedge clk);
    valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_edge = 0; m_run = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check(flag, 1'b1, "R1 flag high during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(flag, 1'b1, "R1 flag high after release");
  endtask

  task automatic word_edge();
    @(negedge clk); wclk = 1'b0;
    @(negedge clk); wclk = 1'b1;
    if (!m_run) m_edge = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R3: word clock high across release is not an edge.
    send('0, '0, 1, "R3 high word clock at release");
    send(16'h1234, '0, 0, "R2 strobe before edge ignored");
    // R2: strobe in the same cycle as the edge stays in start-up.
    @(negedge clk); wclk = 1'b0;
    @(negedge clk); wclk = 1'b1; left = 16'h0042; right = '0; valid = 1'b1;
    sbq.push_back('{exp: 1'b1, tag: "R2 strobe in edge cycle"});
    @(negedge clk); valid = 1'b0; m_edge = 1;
    send(16'h0001, '0, 1, "R2 first data period ends start-up");
    for (int i = 0; i < LIMIT; i++)
      send('0, '0, i % 3, "R5 threshold reached exactly");
    for (int i = 0; i < 20; i++) begin
      wclk = ~wclk;
      send('0, '0, i % 2, "R7 saturated flag holds, R9 word clock ignored");
    end
    send(16'h8000, '0, 0, "R4 left only non-zero");
    for (int i = 0; i < LIMIT; i++)
      send('0, '0, i % 4, "R8 idle gaps do not break run");
    repeat (10) @(negedge clk);
    check(flag, 1'b1, "R8 idle cycles keep flag");
    send('0, 16'hFFFF, 1, "R4 right only non-zero");
    for (int i = 0; i < LIMIT - 1; i++)
      send('0, '0, 0, "R5 one short of threshold");
    send(16'h0100, 16'h0001, 0, "R6 non-zero clears run");
    for (int i = 0; i < LIMIT; i++) begin
      wclk = (i % 2 == 0);
      send('0, '0, 1, "R9 run restarts after clear");
    end
    // Reset in the middle of a silent run.
    wclk = 1'b0;
    do_reset();
    send('0, '0, 1, "R1 no edge yet after reset");
    word_edge();
    send('0, '0, 1, "R2 zero first period ends start-up");
    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard drain: actual %0d items expected 0", sbq.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule